// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three half-bridge legs of a motor inverter. One counter is shared by all three legs. Each leg compares the counter with its own duty value to form a high-side reference. A dead-time stage turns that reference into a complementary pair of gate signals. Both turn-on edges of a pair are held back by a programmable number of clock cycles. Turn-off is never delayed, so the two switches of a leg never conduct together.

The counter runs in one of two alignments. In edge alignment it climbs from zero to the period value and wraps. In center alignment it climbs to the period value and falls back to zero. Period and duty inputs are captured into working registers only at the period boundary, so software can update them at any time without producing a glitch. Once per period, when the counter returns to zero, the block emits a one-cycle trigger that can start an ADC conversion.

Any comparator fault input or external fault pin forces all six gate outputs inactive on the next cycle and sets a sticky fault flag. The outputs stay off until a clear request arrives while every fault input is low.

Top module: `tri_phase_pwm`

## Requirements
- R1: During and after reset, with the enable low, all six gate outputs, the trigger and the fault flag are 0.
- R2: In edge alignment (align_i = 0) with period P, the counter runs 0..P, so one period lasts P+1 cycles. A leg's high-side reference is high for min(D, P+1) of those cycles, where D is the leg's duty.
- R3: In center alignment (align_i = 1) with period P > 0, one period lasts 2P cycles. The reference is high for 0 cycles when D = 0, for 2P cycles when D > P, and for 2D-1 cycles otherwise.
- R4: Each turn-on edge of a gate output lags the matching reference transition by dead_i cycles, and turn-off edges are not delayed. A phase of length H within a period therefore yields max(H - dead_i, 0) active cycles, and both outputs of the pair are low for exactly dead_i cycles at each switch-over.
- R5: When a reference phase is no longer than dead_i cycles, the output for that phase is suppressed completely; an inverted pulse is never produced.
- R6: The high-side and low-side outputs of a leg are never active in the same cycle.
- R7: Changes to period_i and duty_i take effect only at the next period boundary. The current period finishes with the old values.
- R8: adc_trig_o pulses once per period, in the cycle in which the counter is back at zero.
- R9: A high level on any comparator fault input or fault pin makes all six outputs inactive and fault_o high on the next cycle.
- R10: fault_o is sticky. A clear request has no effect while any fault input is high. A clear request with all fault inputs low drops fault_o on the next cycle, and the outputs then resume.
- R11: While en_i is low, the outputs are inactive, no trigger is issued and the counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| align_i | input | 1 | 0 = edge aligned, 1 = center aligned |
| period_i | input | CW | Period value, captured at the boundary |
| duty_i | input | NPAIR*CW | Duty values; leg k at bits k*CW +: CW |
| dead_i | input | DTW | Dead time in clock cycles |
| cmp_flt_i | input | NCMP | Comparator fault inputs, active high |
| pin_flt_i | input | NPIN | External fault pins, active high |
| flt_clr_i | input | 1 | Fault clear request |
| pwm_hi_o | output | NPAIR | High-side gate outputs |
| pwm_lo_o | output | NPAIR | Low-side gate outputs |
| adc_trig_o | output | 1 | Once-per-period ADC start pulse |
| fault_o | output | 1 | Latched fault flag |

## Verification
The bench builds the block with CW = 6, DTW = 4, NCMP = 2 and NPIN = 2, and without output inversion. With a 6-bit counter, full periods in both alignments last at most 128 cycles. This lets the bench cover duties of zero, duties above the period and the maximum period in short windows. With a 4-bit dead time, the largest setting of 15 cycles is reached. That value exceeds some phase lengths, which exercises pulse suppression, and it drives the stable-time counter to saturation. Two inputs on each fault group confirm that every fault source is ORed into the trip latch.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  typedef enum logic {ALIGN_EDGE = 1'b0, ALIGN_CENTER = 1'b1} align_e;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/tpp_counter.sv
// Shared carrier counter with shadowed period/duty and boundary trigger.
module tpp_counter
  import tpp_pkg::*;
#(
  parameter int CW    = 12,
  parameter int NPAIR = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run_i,
  input  align_e                 align_i,
  input  logic [CW-1:0]          period_i,
  input  logic [NPAIR*CW-1:0]    duty_i,
  output logic [CW-1:0]          cnt_o,
  output logic [NPAIR*CW-1:0]    duty_o,
  output logic                   trig_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0]       cnt_q, cnt_n, per_q;
  logic [NPAIR*CW-1:0] duty_q;
  dir_e                dir_q, dir_n;
  logic                load;
  logic                trig_q;

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    load  = 1'b0;
    if (!run_i) begin
      cnt_n = '0;
      dir_n = DIR_UP;
      load  = 1'b1;
    end else if (align_i == ALIGN_EDGE) begin
      dir_n = DIR_UP;
      if (cnt_q >= per_q) begin
        cnt_n = '0;
        load  = 1'b1;
      end else begin
        cnt_n = cnt_q + ONE;
      end
    end else if (per_q == '0) begin
      cnt_n = '0;
      dir_n = DIR_UP;
      load  = 1'b1;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= per_q) begin
        cnt_n = cnt_q - ONE;
        dir_n = DIR_DOWN;
      end else begin
        cnt_n = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == '0) begin
        cnt_n = ONE;
        dir_n = DIR_UP;
        load  = 1'b1;
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
      per_q  <= '0;
      duty_q <= '0;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      dir_q  <= dir_n;
      trig_q <= run_i && (cnt_n == '0);
      if (load) begin
        per_q  <= period_i;
        duty_q <= duty_i;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/tpp_leg.sv
// One inverter leg: compare, stable-time counting, dead-time gated pair.
module tpp_leg #(
  parameter int CW     = 12,
  parameter int DTW    = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  cnt_i,
  input  logic [CW-1:0]  duty_i,
  input  logic [DTW-1:0] dead_i,
  input  logic           gate_i,
  output logic           hi_o,
  output logic           lo_o
);
  logic           ref_q, ref_d;
  logic [DTW-1:0] sc_q;
  logic           hi_q, lo_q;
  logic           settled;

  assign settled = (sc_q >= dead_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      ref_d <= 1'b0;
      sc_q  <= '0;
      hi_q  <= INVERT;
      lo_q  <= INVERT;
    end else begin
      ref_q <= (cnt_i < duty_i);
      ref_d <= ref_q;
      if (ref_q != ref_d) begin
        sc_q <= '0;
      end else if (sc_q != {DTW{1'b1}}) begin
        sc_q <= sc_q + {{(DTW-1){1'b0}}, 1'b1};
      end
      hi_q <= (gate_i &&  ref_d && settled) ^ INVERT;
      lo_q <= (gate_i && !ref_d && settled) ^ INVERT;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/tpp_trip.sv
// Fault combiner with sticky trip flag.
module tpp_trip #(
  parameter int NIN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIN-1:0] flt_i,
  input  logic           clr_i,
  output logic           live_o,
  output logic           latch_o
);
  logic latch_q;

  assign live_o = |flt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
    end else if (live_o) begin
      latch_q <= 1'b1;
    end else if (clr_i) begin
      latch_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
  import tpp_pkg::*;
#(
  parameter int CW     = 12,
  parameter int DTW    = 8,
  parameter int NPAIR  = 3,
  parameter int NCMP   = 2,
  parameter int NPIN   = 2,
  parameter bit INVERT = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic                align_i,
  input  logic [CW-1:0]       period_i,
  input  logic [NPAIR*CW-1:0] duty_i,
  input  logic [DTW-1:0]      dead_i,
  input  logic [NCMP-1:0]     cmp_flt_i,
  input  logic [NPIN-1:0]     pin_flt_i,
  input  logic                flt_clr_i,
  output logic [NPAIR-1:0]    pwm_hi_o,
  output logic [NPAIR-1:0]    pwm_lo_o,
  output logic                adc_trig_o,
  output logic                fault_o
);
  localparam int NIN = NCMP + NPIN;

  logic [CW-1:0]       cnt;
  logic [NPAIR*CW-1:0] duty_act;
  logic                flt_live, flt_latched, gate;

  tpp_counter #(.CW(CW), .NPAIR(NPAIR)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .run_i    (en_i),
    .align_i  (align_e'(align_i)),
    .period_i (period_i),
    .duty_i   (duty_i),
    .cnt_o    (cnt),
    .duty_o   (duty_act),
    .trig_o   (adc_trig_o)
  );

  tpp_trip #(.NIN(NIN)) trip_i (
    .clk     (clk),
    .rst     (rst),
    .flt_i   ({pin_flt_i, cmp_flt_i}),
    .clr_i   (flt_clr_i),
    .live_o  (flt_live),
    .latch_o (flt_latched)
  );

  assign gate    = en_i && !flt_live && !flt_latched;
  assign fault_o = flt_latched;

  for (genvar k = 0; k < NPAIR; k++) begin : g_leg
    tpp_leg #(.CW(CW), .DTW(DTW), .INVERT(INVERT)) leg_i (
      .clk    (clk),
      .rst    (rst),
      .cnt_i  (cnt),
      .duty_i (duty_act[k*CW +: CW]),
      .dead_i (dead_i),
      .gate_i (gate),
      .hi_o   (pwm_hi_o[k]),
      .lo_o   (pwm_lo_o[k])
    );
  end
endmodule

// File: rtl/tri_phase_pwm_chk.sv
module tri_phase_pwm_chk #(
  parameter int NPAIR  = 3,
  parameter int NCMP   = 2,
  parameter int NPIN   = 2,
  parameter bit INVERT = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic [NCMP-1:0]  cmp_flt_i,
  input logic [NPIN-1:0]  pin_flt_i,
  input logic             flt_clr_i,
  input logic [NPAIR-1:0] pwm_hi_o,
  input logic [NPAIR-1:0] pwm_lo_o,
  input logic             adc_trig_o,
  input logic             fault_o
);
  logic [NPAIR-1:0] act_hi, act_lo;
  logic             any_flt, quiet;

  assign act_hi  = pwm_hi_o ^ {NPAIR{INVERT}};
  assign act_lo  = pwm_lo_o ^ {NPAIR{INVERT}};
  assign any_flt = (|cmp_flt_i) || (|pin_flt_i);
  assign quiet   = (act_hi == '0) && (act_lo == '0);

  p_pair_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (act_hi & act_lo) == '0);

  p_fault_off_r9: assert property (@(posedge clk) disable iff (rst)
    any_flt |=> quiet && fault_o);

  p_latch_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !flt_clr_i) |=> fault_o);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (fault_o && flt_clr_i && !any_flt) |=> !fault_o);

  p_latched_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> quiet);

  p_disable_off_r11: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> quiet && !adc_trig_o);
endmodule

bind tri_phase_pwm tri_phase_pwm_chk #(
  .NPAIR(NPAIR), .NCMP(NCMP), .NPIN(NPIN), .INVERT(INVERT)
) chk_i (
  .clk(clk), .rst(rst), .en_i(en_i), .cmp_flt_i(cmp_flt_i),
  .pin_flt_i(pin_flt_i), .flt_clr_i(flt_clr_i), .pwm_hi_o(pwm_hi_o),
  .pwm_lo_o(pwm_lo_o), .adc_trig_o(adc_trig_o), .fault_o(fault_o)
);

// File: tb/tri_phase_pwm_tb_top.sv
module tri_phase_pwm_tb_top;
  localparam int CW = 6, DTW = 4, NPAIR = 3, NCMP = 2, NPIN = 2;
  localparam int NV = 7;
  localparam int VW = 1 + 4*CW + DTW;

  // {center, period, duty0, duty1, duty2, dead}
  localparam logic [VW-1:0] VTAB [NV] = '{
    {1'b0, 6'd9,  6'd3,  6'd5,  6'd10, 4'd0},
    {1'b0, 6'd9,  6'd3,  6'd5,  6'd0,  4'd2},
    {1'b0, 6'd15, 6'd2,  6'd8,  6'd16, 4'd3},
    {1'b1, 6'd8,  6'd1,  6'd4,  6'd9,  4'd0},
    {1'b1, 6'd8,  6'd2,  6'd5,  6'd8,  4'd2},
    {1'b1, 6'd20, 6'd0,  6'd10, 6'd21, 4'd5},
    {1'b0, 6'd63, 6'd32, 6'd1,  6'd63, 4'd15}
  };

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, ctr = 1'b0, clr = 1'b0;
  logic [CW-1:0]       per = '0;
  logic [NPAIR*CW-1:0] duty = '0;
  logic [DTW-1:0]      dead = '0;
  logic [NCMP-1:0]     cmp = '0;
  logic [NPIN-1:0]     pin = '0;
  logic [NPAIR-1:0]    hi, lo;
  logic                trig, fault;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tri_phase_pwm #(.CW(CW), .DTW(DTW), .NPAIR(NPAIR), .NCMP(NCMP),
                  .NPIN(NPIN), .INVERT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .en_i(en), .align_i(ctr), .period_i(per),
    .duty_i(duty), .dead_i(dead), .cmp_flt_i(cmp), .pin_flt_i(pin),
    .flt_clr_i(clr), .pwm_hi_o(hi), .pwm_lo_o(lo), .adc_trig_o(trig),
    .fault_o(fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int win_len(bit c, int p);
    if (c) return (p == 0) ? 1 : 2*p;
    return p + 1;
  endfunction

  function automatic int ref_high(bit c, int p, int d);
    if (d == 0) return 0;
    if (d > p) return win_len(c, p);
    return c ? 2*d - 1 : d;
  endfunction

  function automatic int out_high(int l, int h, int dt);
    if (h == 0) return 0;
    if (h == l) return l;
    return (h > dt) ? h - dt : 0;
  endfunction

  task automatic start(input bit c, input int p, input int d0, input int d1,
                       input int d2, input int dt);
    en = 1'b0;
    @(negedge clk);
    ctr  = c;
    per  = CW'(p);
    duty = {CW'(d2), CW'(d1), CW'(d0)};
    dead = DTW'(dt);
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int act, n;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {29'd0, hi, lo, trig, fault} == 0 ? 0 : 1, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 after reset", int'({hi, lo, trig, fault}), 0);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      bit c;
      int p, dt, l, tc, both;
      int d [NPAIR];
      int hc [NPAIR];
      int lc [NPAIR];
      c  = VTAB[v][VW-1];
      p  = int'(VTAB[v][VW-2 -: CW]);
      for (int k = 0; k < NPAIR; k++) begin
        d[k]  = int'(VTAB[v][VW-2-CW*(k+1) -: CW]);
        hc[k] = 0;
        lc[k] = 0;
      end
      dt = int'(VTAB[v][DTW-1:0]);
      start(c, p, d[0], d[1], d[2], dt);
      l = win_len(c, p);
      repeat (3*l + 8) @(negedge clk);
      tc = 0; both = 0;
      for (int cy = 0; cy < l; cy++) begin
        for (int k = 0; k < NPAIR; k++) begin
          hc[k] += int'(hi[k]);
          lc[k] += int'(lo[k]);
        end
        tc += int'(trig);
        both += int'(|(hi & lo));
        @(negedge clk);
      end
      for (int k = 0; k < NPAIR; k++) begin
        int rh, eh, el;
        rh = ref_high(c, p, d[k]);
        eh = out_high(l, rh, dt);
        el = out_high(l, l - rh, dt);
        chk($sformatf("%s R4 vec%0d leg%0d high side%s", c ? "R3" : "R2", v, k,
                      (eh == 0 && rh > 0) ? " R5" : ""), hc[k], eh);
        chk($sformatf("%s R4 vec%0d leg%0d low side%s", c ? "R3" : "R2", v, k,
                      (el == 0 && rh < l) ? " R5" : ""), lc[k], el);
      end
      chk($sformatf("R8 vec%0d triggers per period", v), tc, 1);
      chk($sformatf("R6 vec%0d overlap cycles", v), both, 0);
    end

    // R11: disable silences everything
    en = 1'b0;
    @(negedge clk);
    act = 0;
    for (int cy = 0; cy < 20; cy++) begin
      act += int'(|hi) + int'(|lo) + int'(trig);
      @(negedge clk);
    end
    chk("R11 activity while disabled", act, 0);

    // R4: dead gap at switch-over
    start(1'b0, 19, 10, 0, 0, 4);
    n = 0;
    while (!hi[0] && n < 200) begin n++; @(negedge clk); end
    while (hi[0] && n < 400) begin n++; @(negedge clk); end
    act = 0;
    while (!lo[0] && act < 100) begin act++; @(negedge clk); end
    chk("R4 gap between high-side off and low-side on", act, 4);

    // R7: period change waits for boundary
    start(1'b0, 20, 10, 5, 15, 0);
    n = 0;
    while (!trig && n < 200) begin n++; @(negedge clk); end
    per = 6'd10;
    n = 0;
    do begin @(negedge clk); n++; end while (!trig && n < 200);
    chk("R7 interval with old period", n, 21);
    n = 0;
    do begin @(negedge clk); n++; end while (!trig && n < 200);
    chk("R7 interval with new period", n, 11);

    // R9 / R10: comparator fault
    start(1'b0, 19, 10, 10, 10, 0);
    repeat (30) @(negedge clk);
    cmp = 2'b10;
    @(negedge clk);
    chk("R9 outputs after comparator fault", int'({hi, lo}), 0);
    chk("R9 fault flag set", int'(fault), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 clear ignored while fault high", int'(fault), 1);
    cmp = 2'b00;
    act = 0;
    for (int cy = 0; cy < 10; cy++) begin
      @(negedge clk);
      act += int'(|hi) + int'(|lo) + int'(!fault);
    end
    chk("R10 latched off after fault release", act, 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 flag cleared", int'(fault), 0);
    act = 0;
    for (int cy = 0; cy < 20; cy++) begin
      act += int'(hi[0]) + int'(lo[0]);
      @(negedge clk);
    end
    chk("R10 outputs resume", (act > 0) ? 1 : 0, 1);

    // R9: one-cycle fault pin pulse
    pin = 2'b01;
    @(negedge clk);
    pin = 2'b00;
    chk("R9 pin fault outputs", int'({hi, lo}), 0);
    repeat (5) @(negedge clk);
    chk("R9 pin fault latched", int'(fault), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 pin fault cleared", int'(fault), 0);

    finish_run();
  end
endmodule